// File: doc/BRIEF.md
# Parameter-Set Link Engine

This block is the control engine of one fast-start DMA channel. The channel keeps a small RAM of parameter sets, each eight 32-bit words long. Slot 0 is the active set. The other slots hold sets that can be chained behind it. Software writes the sets through a word-addressed write port. A write to the trigger word of the active set starts work. The engine sorts the active set into one of three kinds:

- a real transfer, which it hands to an external data mover through a request/accept/done handshake;
- a dummy, which finishes at once and moves no data;
- a null set, which is an error.

When a set finishes, the engine follows the set's link field. If the link is null, the engine reports completion and carries a code taken from the options word. Otherwise it copies the named set over slot 0, one word per cycle. Writing the trigger word during that copy starts the newly loaded set. A chain can therefore hold dummies in the middle and still keep running to its last set.

Top module: `plink_engine`

## Requirements
- R1: While reset is held and right after it is released, `xfer_req`, `cmpl_pulse` and `null_err` are low, and `xfer_param` is all zeros.
- R2: A write on the configuration port stores `cfg_wdata` at word index `cfg_widx`, where set s, word w has index 8*s+w. The active set appears on `xfer_param`, with word w on bits [32w+31:32w]. The field layout is:
  - word 0 holds the options, with the AB-synchronized select in bit 2 and the 6-bit completion code in bits [17:12];
  - word 1 holds the source address;
  - word 2 holds the first count in bits [15:0] and the second count in bits [31:16];
  - word 5 holds the link byte offset in bits [15:0];
  - word 7 holds the third count in bits [15:0].
- R3: A write to word index 7 (the trigger word of slot 0) starts the set only when `chan_en` is high. With `chan_en` low the data is stored but no request, completion or error follows.
- R4: A set whose three counts are all non-zero is a real transfer. After the trigger write is sampled on a rising edge, `xfer_req` is low after that edge and high after the next one. It then stays high until a cycle in which `xfer_ack` is high.
- R5: When a set finishes and its link is not 0xFFFF, the eight words of the set at byte offset link are copied into slot 0. Link bits [4:0] and the bits above the RAM size are ignored. The copy then triggers the loaded set as long as `chan_en` is high.
- R6: A set with some, but not all, counts at zero is a dummy. It raises no request, finishes at once, and its link is followed like that of a real set.
- R7: A set with all three counts at zero raises a one-cycle `null_err`. It raises no request and no completion, and its link is not followed.
- R8: When a real or dummy set with link 0xFFFF finishes, `cmpl_pulse` is high for exactly one cycle, and `cmpl_code` then equals bits [17:12] of that set's options word.
- R9: Configuration writes made while a link copy is in progress are discarded.
- R10: A trigger write made while a transfer is pending or in flight stores its data but starts no second transfer.
- R11: A chain of four sets with a dummy as the second set issues exactly three requests, with the sources of sets 1, 3 and 4 in that order, and then raises one completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable, gates all triggering |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_widx | input | $clog2(NUM_SETS*8) | Word index of the write into the set RAM |
| cfg_wdata | input | 32 | Write data |
| xfer_req | output | 1 | Transfer request to the data mover |
| xfer_ack | input | 1 | Data mover accepts the request |
| xfer_done | input | 1 | Data mover finished the accepted transfer |
| xfer_param | output | 256 | The eight words of the active set |
| cmpl_pulse | output | 1 | One-cycle end-of-chain pulse |
| cmpl_code | output | 6 | Completion code that goes with `cmpl_pulse` |
| null_err | output | 1 | One-cycle pulse for a set with all counts zero |

## Verification
The assertions assume the following about the data mover:
- it raises `xfer_ack` only while `xfer_req` is high;
- it raises `xfer_done` once per accepted request, only after the accept and before any new request.

The bench's mover model holds to this. It raises accept for one cycle on the first sampled request, waits two cycles, and then gives one done pulse. The bench makes configuration writes only at negative edges. During a link copy it writes only in the deliberate cycles that test for discarded writes.

// File: rtl/plink_pkg.sv
package plink_pkg;

    localparam int WORD_W      = 32;
    localparam int SET_WORDS   = 8;
    localparam int WSEL_W      = 3;
    localparam int SET_BYTE_SH = 5;

    localparam int W_OPT  = 0;
    localparam int W_SRC  = 1;
    localparam int W_CNT  = 2;
    localparam int W_LINK = 5;
    localparam int W_TRIG = 7;

    localparam int CNT_W    = 16;
    localparam int CODE_LSB = 12;
    localparam int CODE_W   = 6;

    localparam logic [CNT_W-1:0] LINK_NONE = 16'hFFFF;

    typedef enum logic [1:0] {
        KIND_REAL,
        KIND_DUMMY,
        KIND_NULL
    } set_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_COPY
    } eng_state_e;

    function automatic set_kind_e classify_counts(input logic [CNT_W-1:0] a,
                                                  input logic [CNT_W-1:0] b,
                                                  input logic [CNT_W-1:0] c);
        if (a != '0 && b != '0 && c != '0)
            return KIND_REAL;
        else if (a == '0 && b == '0 && c == '0)
            return KIND_NULL;
        else
            return KIND_DUMMY;
    endfunction

endpackage

// File: rtl/plink_set_ram.sv
module plink_set_ram import plink_pkg::*; #(
    parameter int NUM_SETS = 4,
    parameter int IDX_W    = 5
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en,
    input  logic [IDX_W-1:0]                   wr_idx,
    input  logic [WORD_W-1:0]                  wr_data,
    input  logic [IDX_W-1:0]                   rd_idx,
    output logic [WORD_W-1:0]                  rd_data,
    output logic [SET_WORDS-1:0][WORD_W-1:0]   act_words
);
    localparam int DEPTH = NUM_SETS * SET_WORDS;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

    // Slot 0 is always visible to the data mover and the control logic
    for (genvar g = 0; g < SET_WORDS; g++) begin : g_active
        assign act_words[g] = mem[g];
    end

    // R2: an accepted write is present in the array one cycle later
    a_r2_word_stored: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mem[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/plink_decode.sv
module plink_decode import plink_pkg::*; #(
    parameter int SET_W = 2
) (
    input  logic [CNT_W-1:0] acnt,
    input  logic [CNT_W-1:0] bcnt,
    input  logic [CNT_W-1:0] ccnt,
    input  logic [CNT_W-1:0] link,
    output set_kind_e        kind,
    output logic             link_null,
    output logic [SET_W-1:0] link_set
);
    assign kind      = classify_counts(acnt, bcnt, ccnt);
    assign link_null = (link == LINK_NONE);
    // Byte offset to set number: drop the in-set offset, keep what fits the RAM
    assign link_set  = link[SET_BYTE_SH +: SET_W];
endmodule

// File: rtl/plink_seq.sv
module plink_seq import plink_pkg::*; #(
    parameter int SET_W = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      chan_en,
    input  logic                      sw_trig,
    input  set_kind_e                 kind,
    input  logic                      link_null,
    input  logic [SET_W-1:0]          link_set,
    input  logic [CODE_W-1:0]         code_field,
    input  logic                      xfer_ack,
    input  logic                      xfer_done,
    output logic                      xfer_req,
    output logic                      copy_busy,
    output logic [WSEL_W-1:0]         copy_sel,
    output logic [SET_W+WSEL_W-1:0]   copy_src_idx,
    output logic                      cmpl_pulse,
    output logic [CODE_W-1:0]         cmpl_code,
    output logic                      null_err
);
    eng_state_e        st;
    logic              pend;
    logic [WSEL_W-1:0] cnt;
    logic [SET_W-1:0]  src_set;
    logic              fin;

    // A set finishes when a dummy is evaluated or the mover reports done
    assign fin = (st == ST_IDLE && pend && kind == KIND_DUMMY) ||
                 (st == ST_WAIT && xfer_done);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            pend       <= 1'b0;
            cnt        <= '0;
            src_set    <= '0;
            cmpl_pulse <= 1'b0;
            cmpl_code  <= '0;
            null_err   <= 1'b0;
        end else begin
            cmpl_pulse <= 1'b0;
            null_err   <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (pend) begin
                        if (kind == KIND_REAL) begin
                            st <= ST_REQ;
                        end else begin
                            pend <= 1'b0;
                            if (kind == KIND_NULL)
                                null_err <= 1'b1;
                        end
                    end else if (sw_trig && chan_en) begin
                        pend <= 1'b1;
                    end
                end
                ST_REQ: begin
                    if (xfer_ack) begin
                        pend <= 1'b0;
                        st   <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                end
                ST_COPY: begin
                    cnt <= cnt + 3'd1;
                    if (cnt == 3'(SET_WORDS - 1)) begin
                        st   <= ST_IDLE;
                        pend <= chan_en;   // reload writes the trigger word
                    end
                end
            endcase
            if (fin) begin
                if (link_null) begin
                    cmpl_pulse <= 1'b1;
                    cmpl_code  <= code_field;
                    st         <= ST_IDLE;
                end else begin
                    st      <= ST_COPY;
                    cnt     <= '0;
                    src_set <= link_set;
                end
            end
        end
    end

    assign xfer_req     = (st == ST_REQ);
    assign copy_busy    = (st == ST_COPY);
    assign copy_sel     = cnt;
    assign copy_src_idx = {src_set, cnt};

    // R4: request is held until the mover accepts it
    a_r4_req_held: assert property (@(posedge clk) disable iff (rst)
        xfer_req && !xfer_ack |=> xfer_req);

    // R8: completion is a single-cycle pulse
    a_r8_pulse_once: assert property (@(posedge clk) disable iff (rst)
        cmpl_pulse |=> !cmpl_pulse);

    // R7: a null set raises neither a completion nor a request
    a_r7_err_alone: assert property (@(posedge clk) disable iff (rst)
        null_err |-> !cmpl_pulse && !xfer_req);

    // R6: a dummy or null set never leads to a request in the next cycle
    a_r6_dummy_no_req: assert property (@(posedge clk) disable iff (rst)
        st == ST_IDLE && pend && kind != KIND_REAL |=> !xfer_req);

endmodule

// File: rtl/plink_engine.sv
module plink_engine import plink_pkg::*; #(
    parameter int NUM_SETS = 4
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   chan_en,
    input  logic                                   cfg_we,
    input  logic [$clog2(NUM_SETS*SET_WORDS)-1:0]  cfg_widx,
    input  logic [WORD_W-1:0]                      cfg_wdata,
    output logic                                   xfer_req,
    input  logic                                   xfer_ack,
    input  logic                                   xfer_done,
    output logic [SET_WORDS*WORD_W-1:0]            xfer_param,
    output logic                                   cmpl_pulse,
    output logic [CODE_W-1:0]                      cmpl_code,
    output logic                                   null_err
);
    localparam int DEPTH = NUM_SETS * SET_WORDS;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int SET_W = IDX_W - WSEL_W;
    localparam logic [IDX_W-1:0] TRIG_IDX = IDX_W'(W_TRIG);

    logic [SET_WORDS-1:0][WORD_W-1:0] act_words;
    logic [WORD_W-1:0]                rd_data;
    logic                             copy_busy;
    logic [WSEL_W-1:0]                copy_sel;
    logic [IDX_W-1:0]                 copy_src_idx;
    logic                             ram_we;
    logic [IDX_W-1:0]                 ram_widx;
    logic [WORD_W-1:0]                ram_wdata;
    logic                             sw_trig;
    set_kind_e                        kind;
    logic                             link_null;
    logic [SET_W-1:0]                 link_set;

    // The link copy owns the write port; software writes are dropped meanwhile
    assign ram_we    = copy_busy ? 1'b1 : cfg_we;
    assign ram_widx  = copy_busy ? IDX_W'(copy_sel) : cfg_widx;
    assign ram_wdata = copy_busy ? rd_data : cfg_wdata;
    assign sw_trig   = cfg_we && !copy_busy && (cfg_widx == TRIG_IDX);

    plink_set_ram #(.NUM_SETS(NUM_SETS), .IDX_W(IDX_W)) u_ram (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (ram_we),
        .wr_idx    (ram_widx),
        .wr_data   (ram_wdata),
        .rd_idx    (copy_src_idx),
        .rd_data   (rd_data),
        .act_words (act_words)
    );

    plink_decode #(.SET_W(SET_W)) u_dec (
        .acnt      (act_words[W_CNT][CNT_W-1:0]),
        .bcnt      (act_words[W_CNT][WORD_W-1:CNT_W]),
        .ccnt      (act_words[W_TRIG][CNT_W-1:0]),
        .link      (act_words[W_LINK][CNT_W-1:0]),
        .kind      (kind),
        .link_null (link_null),
        .link_set  (link_set)
    );

    plink_seq #(.SET_W(SET_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .chan_en      (chan_en),
        .sw_trig      (sw_trig),
        .kind         (kind),
        .link_null    (link_null),
        .link_set     (link_set),
        .code_field   (act_words[W_OPT][CODE_LSB +: CODE_W]),
        .xfer_ack     (xfer_ack),
        .xfer_done    (xfer_done),
        .xfer_req     (xfer_req),
        .copy_busy    (copy_busy),
        .copy_sel     (copy_sel),
        .copy_src_idx (copy_src_idx),
        .cmpl_pulse   (cmpl_pulse),
        .cmpl_code    (cmpl_code),
        .null_err     (null_err)
    );

    assign xfer_param = act_words;

    // R9: no request is raised while a link copy is running
    a_r9_copy_quiet: assert property (@(posedge clk) disable iff (rst)
        copy_busy && $past(copy_busy) |-> !xfer_req && !cmpl_pulse);

endmodule

// File: tb/plink_engine_test.sv
module plink_engine_test;
    localparam int NUM_SETS = 4;
    localparam int IDX_W    = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         chan_en = 1'b1;
    logic         cfg_we = 1'b0;
    logic [IDX_W-1:0] cfg_widx = '0;
    logic [31:0]  cfg_wdata = '0;
    logic         xfer_req;
    logic         xfer_ack = 1'b0;
    logic         xfer_done = 1'b0;
    logic [255:0] xfer_param;
    logic         cmpl_pulse;
    logic [5:0]   cmpl_code;
    logic         null_err;

    int checks = 0;
    int errors = 0;
    int nreq = 0, ncmpl = 0, nerr = 0, cyc = 0;
    logic [5:0] last_code = '0;
    logic req_prev = 1'b0;

    always #5 clk = ~clk;

    plink_engine #(.NUM_SETS(NUM_SETS)) uut (
        .clk(clk), .rst(rst), .chan_en(chan_en),
        .cfg_we(cfg_we), .cfg_widx(cfg_widx), .cfg_wdata(cfg_wdata),
        .xfer_req(xfer_req), .xfer_ack(xfer_ack), .xfer_done(xfer_done),
        .xfer_param(xfer_param), .cmpl_pulse(cmpl_pulse),
        .cmpl_code(cmpl_code), .null_err(null_err)
    );

    // Event monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (xfer_req && !req_prev) nreq++;
            if (cmpl_pulse) begin ncmpl++; last_code = cmpl_code; end
            if (null_err) nerr++;
        end
        req_prev = xfer_req;
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog (all requirements) actual=%0d expected<%0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_widx = IDX_W'(idx); cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    // Data mover model: accept, wait, done; optionally poke set 1 word 1 during the copy
    task automatic serve(output logic [31:0] src, input bit poke);
        bit seen;
        seen = 1'b0;
        src = '0;
        for (int k = 0; k < 80 && !seen; k++) begin
            @(negedge clk);
            if (xfer_req) seen = 1'b1;
        end
        if (!seen) begin
            chk(1'b0, "R4 request never raised", 32'd0, 32'd1);
        end else begin
            src = xfer_param[63:32];
            xfer_ack = 1'b1;
            @(negedge clk); xfer_ack = 1'b0;
            repeat (2) @(negedge clk);
            xfer_done = 1'b1;
            @(negedge clk); xfer_done = 1'b0;
            if (poke) begin cfg_we = 1'b1; cfg_widx = IDX_W'(9); cfg_wdata = 32'hBAD; end
            @(negedge clk); cfg_we = 1'b0;
        end
    endtask

    // {first count, second count, third count, kind: 0 real, 1 dummy, 2 null}
    localparam logic [49:0] VEC [8] = '{
        {16'd4,    16'd1, 16'd1, 2'd0},
        {16'd0,    16'd1, 16'd1, 2'd1},
        {16'd4,    16'd0, 16'd1, 2'd1},
        {16'd4,    16'd1, 16'd0, 2'd1},
        {16'd0,    16'd0, 16'd1, 2'd1},
        {16'd0,    16'd0, 16'd0, 2'd2},
        {16'h0010, 16'd2, 16'd3, 2'd0},
        {16'd0,    16'd5, 16'd0, 2'd1}
    };

    initial begin
        logic [31:0] got;
        int r0, c0, e0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(xfer_req == 1'b0 && cmpl_pulse == 1'b0 && null_err == 1'b0, "R1 outputs during reset",
            {29'd0, xfer_req, cmpl_pulse, null_err}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(xfer_req == 1'b0 && cmpl_pulse == 1'b0 && null_err == 1'b0, "R1 outputs after reset",
            {29'd0, xfer_req, cmpl_pulse, null_err}, 32'd0);
        chk(xfer_param == '0, "R1 active set cleared", xfer_param[31:0], 32'd0);

        // Vector walk: classification of the active set
        for (int i = 0; i < 8; i++) begin
            logic [15:0] a, b, c;
            logic [1:0]  k;
            {a, b, c, k} = VEC[i];
            r0 = nreq; c0 = ncmpl; e0 = nerr;
            wr(0, (32'(i + 1) << 12) | (32'(i & 1) << 2));
            wr(1, 32'h1000 + 32'(i));
            wr(2, {b, a});
            wr(5, 32'h0000FFFF);
            wr(7, {16'h0, c});
            if (k == 2'd0) begin
                chk(xfer_req == 1'b0, "R4 request not yet raised", {31'd0, xfer_req}, 32'd0);
                @(negedge clk);
                chk(xfer_req == 1'b1, "R4 request raised on second edge", {31'd0, xfer_req}, 32'd1);
                chk(xfer_param[2] == 1'(i & 1), "R2 AB-sync bit carried", {31'd0, xfer_param[2]}, 32'(i & 1));
                serve(got, 1'b0);
                chk(got == 32'h1000 + 32'(i), "R2 source word on request", got, 32'h1000 + 32'(i));
            end
            repeat (4) @(negedge clk);
            if (k == 2'd2) begin
                chk(nerr - e0 == 1, "R7 null set flagged", 32'(nerr - e0), 32'd1);
                chk(ncmpl == c0 && nreq == r0, "R7 null set no request/completion",
                    32'(ncmpl - c0 + nreq - r0), 32'd0);
            end else begin
                chk(nreq - r0 == ((k == 2'd0) ? 1 : 0), (k == 2'd0) ? "R4 one request" : "R6 dummy no request",
                    32'(nreq - r0), (k == 2'd0) ? 32'd1 : 32'd0);
                chk(ncmpl - c0 == 1, "R8 completion on null link", 32'(ncmpl - c0), 32'd1);
                chk(last_code == 6'(i + 1), "R8 completion code", {26'd0, last_code}, 32'(i + 1));
            end
        end

        // R3: disabled channel ignores trigger
        chan_en = 1'b0;
        r0 = nreq; c0 = ncmpl; e0 = nerr;
        wr(2, {16'd1, 16'd4});
        wr(7, 32'd1);
        repeat (8) @(negedge clk);
        chk(nreq == r0 && ncmpl == c0 && nerr == e0, "R3 disabled trigger ignored",
            32'(nreq - r0 + ncmpl - c0 + nerr - e0), 32'd0);
        chk(xfer_param[239:224] == 16'd1, "R3 trigger data still stored", {16'd0, xfer_param[239:224]}, 32'd1);
        chan_en = 1'b1;

        // R10: trigger written while a transfer is in flight
        r0 = nreq; c0 = ncmpl;
        wr(0, 32'(5) << 12);
        wr(5, 32'h0000FFFF);
        wr(7, 32'd1);
        for (int k = 0; k < 20 && !xfer_req; k++) @(negedge clk);
        xfer_ack = 1'b1;
        @(negedge clk); xfer_ack = 1'b0;
        cfg_we = 1'b1; cfg_widx = IDX_W'(7); cfg_wdata = 32'd3;
        @(negedge clk); cfg_we = 1'b0;
        xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
        repeat (10) @(negedge clk);
        chk(nreq - r0 == 1, "R10 no second transfer", 32'(nreq - r0), 32'd1);
        chk(ncmpl - c0 == 1, "R10 single completion", 32'(ncmpl - c0), 32'd1);
        chk(xfer_param[239:224] == 16'd3, "R10 busy write stored", {16'd0, xfer_param[239:224]}, 32'd3);

        // R9: writes during the link copy are discarded
        wr(8, 32'(9) << 12);
        wr(9, 32'h000000E1);
        wr(10, {16'd1, 16'd2});
        wr(13, 32'h0000FFFF);
        wr(15, 32'd2);
        wr(1, 32'h000000E0);
        wr(2, {16'd1, 16'd2});
        wr(5, 32'h00000020);
        wr(7, 32'd1);
        c0 = ncmpl;
        serve(got, 1'b1);
        chk(got == 32'hE0, "R9 first source", got, 32'hE0);
        serve(got, 1'b0);
        chk(got == 32'hE1, "R9 write during copy discarded", got, 32'hE1);
        repeat (4) @(negedge clk);
        chk(last_code == 6'd9 && ncmpl - c0 == 1, "R5 linked set completion code",
            {26'd0, last_code}, 32'd9);

        // R11 / R5 / R6: four-set chain with a dummy second
        wr(8, 32'h0);  wr(9, 32'hB0);  wr(10, {16'd1, 16'd4}); wr(13, 32'h0045); wr(15, 32'd0);
        wr(16, 32'h0); wr(17, 32'hC0); wr(18, {16'd1, 16'd4}); wr(21, 32'h0060); wr(23, 32'd1);
        wr(24, 32'h2A << 12); wr(25, 32'hD0); wr(26, {16'd2, 16'd8}); wr(29, 32'hFFFF); wr(31, 32'd3);
        wr(0, 32'h0); wr(1, 32'hA0); wr(2, {16'd1, 16'd4}); wr(5, 32'h0020);
        r0 = nreq; c0 = ncmpl; e0 = nerr;
        wr(7, 32'd1);
        serve(got, 1'b0);
        chk(got == 32'hA0, "R11 first transfer", got, 32'hA0);
        serve(got, 1'b0);
        chk(got == 32'hC0, "R6 dummy skipped, third set next", got, 32'hC0);
        serve(got, 1'b0);
        chk(got == 32'hD0, "R5 link offset low bits ignored, last set", got, 32'hD0);
        repeat (6) @(negedge clk);
        chk(nreq - r0 == 3, "R11 three requests", 32'(nreq - r0), 32'd3);
        chk(ncmpl - c0 == 1 && nerr == e0, "R11 one completion", 32'(ncmpl - c0), 32'd1);
        chk(last_code == 6'h2A, "R11 chain completion code", {26'd0, last_code}, 32'h2A);

        summary();
        $finish;
    end

endmodule